// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the line sync, frame sync, data-enable and pixel coordinate signals for a parallel RGB TFT panel. A small word-addressed register file holds the timing: pulse widths for both syncs, the horizontal and vertical totals, and the first and one-past-last position of the visible area in each direction. Each register carries absolute counter positions, so software computes them from the panel's porches once and the generator only compares.

The scan advances by one pixel on every clock cycle in which the pixel clock enable is high. Timing values are copied into shadow registers when scanning starts and on every frame wrap, so software may rewrite them at any moment without tearing the frame on screen. Shutdown is graceful: a stop request lets the current frame finish, after which the outputs rest at their inactive levels and a sticky status flag reports that the scan has stopped.

A three-state sequencer governs the scan. `ST_IDLE` holds the counters at zero; a start request moves it to `ST_RUN` (loading the shadows). A stop request in `ST_RUN` moves it to `ST_DRAIN`, which keeps scanning; the last pixel of the frame takes `ST_DRAIN` back to `ST_IDLE` and sets the status flag, while a start-only request in `ST_DRAIN` returns to `ST_RUN` and cancels the stop. A stop request in `ST_IDLE` stays in `ST_IDLE` and sets the flag at once.

Top module: `lcd_sync_timing_gen`

## Requirements
- R1: Registers sit at byte offsets 0x00 configuration (bits 11:8 kept), 0x04 frame sync width (bits 9:0), 0x08 line sync width (bits 9:0), 0x0C totals (line total in 31:16, frame total in 15:0), 0x10 horizontal window (start 31:16, end 15:0), 0x14 vertical window (same packing), 0x30 control, 0x34 status; a read returns the kept bits and zero elsewhere.
- R2: The horizontal and vertical positions change only in cycles where `pix_ce` is high; with it low they hold.
- R3: While scanning, `pix_x_o` counts 0 to line total minus one, and at that wrap `pix_y_o` steps, itself wrapping from frame total minus one to 0.
- R4: Line sync is active while `pix_x_o` is below the line sync width; frame sync is active while `pix_y_o` is below the frame sync width.
- R5: Data-enable is active when the horizontal position lies in [start, end) of the horizontal window and the vertical position in [start, end) of the vertical window.
- R6: Configuration bit 11 makes line sync active low, bit 8 makes frame sync active low, bit 9 makes data-enable active low; these take effect on the cycle after the write.
- R7: `pclk_falling_o` follows configuration bit 10 (1 means drive data on the falling pixel clock edge).
- R8: Writes to the timing registers are used from the first pixel of the next frame; the frame in progress keeps the old values.
- R9: After a stop request while scanning, scanning continues to the last pixel of the frame that finishes after the request; then the positions are zero and all three signals rest at their inactive level.
- R10: Status bit 0 becomes 1 when the scan stops and stays 1; a status write with bit 0 equal to 0 clears it, a write with bit 0 equal to 1 changes nothing.
- R11: Control bit 3 starts the scan from idle and bit 4 requests a stop; with both set the stop wins; a start-only write while draining cancels the stop. Control reads return bit 3 = scanning, bit 4 = stop pending.
- R12: A stop request while already idle sets status bit 0 on the next cycle.
- R13: After reset the scan is idle, positions are zero, all registers read zero and all three signals are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel advance enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Line sync after polarity |
| vsync_o | output | 1 | Frame sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| pclk_falling_o | output | 1 | Output-edge select for the pixel clock |
| pix_x_o | output | 16 | Horizontal position |
| pix_y_o | output | 16 | Vertical position |

## Verification
The assertions assume that each total programmed before a start or a frame wrap is at least one, and that sync widths and window edges lie at or below the matching total; without that the range and stop-position properties have no meaning. The bench programs only such consistent timing, writes the totals before starting and changes them only while scanning, where the shadows protect the frame in flight. It keeps `pix_ce` high except in one directed hold window, so every expected position follows from the count of clock edges since the start request.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // Field widths fixed by the 32-bit register packing.
    localparam int REG_W  = 32;
    localparam int POS_W  = 16;
    localparam int SYNC_W = 10;

    // Byte offsets of the register file.
    localparam int OFS_CFG    = 'h00;
    localparam int OFS_VSW    = 'h04;
    localparam int OFS_HSW    = 'h08;
    localparam int OFS_TOTAL  = 'h0C;
    localparam int OFS_HWIN   = 'h10;
    localparam int OFS_VWIN   = 'h14;
    localparam int OFS_CTRL   = 'h30;
    localparam int OFS_STATUS = 'h34;

    // Configuration bit positions (bit 8 is the lowest kept bit).
    localparam int CFG_LSB      = 8;
    localparam int CFG_VS_LOW   = 8;
    localparam int CFG_DE_LOW   = 9;
    localparam int CFG_PCLK_NEG = 10;
    localparam int CFG_HS_LOW   = 11;
    localparam int CFG_KEEP     = 4;

    // Control bit positions.
    localparam int CTL_START = 3;
    localparam int CTL_STOP  = 4;

    typedef struct packed {
        logic [SYNC_W-1:0] hsw;
        logic [SYNC_W-1:0] vsw;
        logic [POS_W-1:0]  htot;
        logic [POS_W-1:0]  vtot;
        logic [POS_W-1:0]  hbeg;
        logic [POS_W-1:0]  hend;
        logic [POS_W-1:0]  vbeg;
        logic [POS_W-1:0]  vend;
    } lcdt_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } lcdt_state_e;

endpackage

// File: rtl/lcdt_regfile.sv
module lcdt_regfile
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic                scanning,
    input  logic                draining,
    input  logic                stop_done,
    output lcdt_timing_t        timing_o,
    output logic [CFG_KEEP-1:0] cfg_o,
    output logic                req_start_o,
    output logic                req_stop_o,
    output logic                stat_o
);

    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_VSW    = ADDR_W'(OFS_VSW);
    localparam logic [ADDR_W-1:0] A_HSW    = ADDR_W'(OFS_HSW);
    localparam logic [ADDR_W-1:0] A_TOTAL  = ADDR_W'(OFS_TOTAL);
    localparam logic [ADDR_W-1:0] A_HWIN   = ADDR_W'(OFS_HWIN);
    localparam logic [ADDR_W-1:0] A_VWIN   = ADDR_W'(OFS_VWIN);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    lcdt_timing_t        tim_q;
    logic [CFG_KEEP-1:0] cfg_q;
    logic                stat_q;

    // Programmed timing and configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q <= '0;
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                A_CFG:   cfg_q <= wdata[CFG_LSB +: CFG_KEEP];
                A_VSW:   tim_q.vsw <= wdata[SYNC_W-1:0];
                A_HSW:   tim_q.hsw <= wdata[SYNC_W-1:0];
                A_TOTAL: begin
                    tim_q.htot <= wdata[2*POS_W-1:POS_W];
                    tim_q.vtot <= wdata[POS_W-1:0];
                end
                A_HWIN: begin
                    tim_q.hbeg <= wdata[2*POS_W-1:POS_W];
                    tim_q.hend <= wdata[POS_W-1:0];
                end
                A_VWIN: begin
                    tim_q.vbeg <= wdata[2*POS_W-1:POS_W];
                    tim_q.vend <= wdata[POS_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Sticky stopped flag: a set from the sequencer beats a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (stop_done) begin
            stat_q <= 1'b1;
        end else if (we && addr == A_STATUS && !wdata[0]) begin
            stat_q <= 1'b0;
        end
    end

    assign req_start_o = we && (addr == A_CTRL) && wdata[CTL_START];
    assign req_stop_o  = we && (addr == A_CTRL) && wdata[CTL_STOP];

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:    rdata[CFG_LSB +: CFG_KEEP] = cfg_q;
            A_VSW:    rdata[SYNC_W-1:0] = tim_q.vsw;
            A_HSW:    rdata[SYNC_W-1:0] = tim_q.hsw;
            A_TOTAL:  rdata = {tim_q.htot, tim_q.vtot};
            A_HWIN:   rdata = {tim_q.hbeg, tim_q.hend};
            A_VWIN:   rdata = {tim_q.vbeg, tim_q.vend};
            A_CTRL: begin
                rdata[CTL_START] = scanning;
                rdata[CTL_STOP]  = draining;
            end
            A_STATUS: rdata[0] = stat_q;
            default:  rdata = '0;
        endcase
    end

    assign timing_o = tim_q;
    assign cfg_o    = cfg_q;
    assign stat_o   = stat_q;

endmodule

// File: rtl/lcdt_seq_fsm.sv
module lcdt_seq_fsm
    import lcdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_start,
    input  logic req_stop,
    input  logic frame_last,
    output logic scanning,
    output logic draining,
    output logic load_start,
    output logic stop_done
);

    lcdt_state_e state_q;
    lcdt_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and outputs.
    always_comb begin
        state_d    = state_q;
        scanning   = 1'b0;
        draining   = 1'b0;
        load_start = 1'b0;
        stop_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_stop) begin
                    stop_done = 1'b1;
                end else if (req_start) begin
                    state_d    = ST_RUN;
                    load_start = 1'b1;
                end
            end
            ST_RUN: begin
                scanning = 1'b1;
                if (req_stop) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                scanning = 1'b1;
                draining = 1'b1;
                if (req_start && !req_stop) begin
                    state_d = ST_RUN;
                end else if (frame_last) begin
                    state_d   = ST_IDLE;
                    stop_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic             scanning,
    input  logic             load_start,
    input  lcdt_timing_t     live_i,
    output lcdt_timing_t     shadow_o,
    output logic [POS_W-1:0] h_o,
    output logic [POS_W-1:0] v_o,
    output logic             frame_last_o,
    output logic [2:0]       raw_o
);

    localparam int PAD_W = POS_W - SYNC_W;

    lcdt_timing_t     sh_q;
    logic [POS_W-1:0] h_q;
    logic [POS_W-1:0] v_q;
    logic             h_last;
    logic             v_last;
    logic             frame_last;
    logic             h_in;
    logic             v_in;

    assign h_last     = (h_q == sh_q.htot - POS_W'(1));
    assign v_last     = (v_q == sh_q.vtot - POS_W'(1));
    assign frame_last = scanning && pix_ce && h_last && v_last;

    // Shadow copy taken at scan start and at every frame wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_start || frame_last) begin
            sh_q <= live_i;
        end
    end

    // Position counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (!scanning) begin
            h_q <= '0;
            v_q <= '0;
        end else if (pix_ce) begin
            if (h_last) begin
                h_q <= '0;
                v_q <= v_last ? '0 : v_q + POS_W'(1);
            end else begin
                h_q <= h_q + POS_W'(1);
            end
        end
    end

    assign h_in = (h_q >= sh_q.hbeg) && (h_q < sh_q.hend);
    assign v_in = (v_q >= sh_q.vbeg) && (v_q < sh_q.vend);

    // raw_o: [0] line sync, [1] frame sync, [2] data-enable; all active high.
    assign raw_o[0] = scanning && (h_q < {{PAD_W{1'b0}}, sh_q.hsw});
    assign raw_o[1] = scanning && (v_q < {{PAD_W{1'b0}}, sh_q.vsw});
    assign raw_o[2] = scanning && h_in && v_in;

    assign shadow_o     = sh_q;
    assign h_o          = h_q;
    assign v_o          = v_q;
    assign frame_last_o = frame_last;

endmodule

// File: rtl/lcdt_pin_drive.sv
module lcdt_pin_drive #(
    parameter int N_SIG = 3
) (
    input  logic [N_SIG-1:0] raw_i,
    input  logic [N_SIG-1:0] act_low_i,
    output logic [N_SIG-1:0] pin_o
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_pol
        assign pin_o[g] = raw_i[g] ^ act_low_i[g];
    end

endmodule

// File: rtl/lcd_sync_timing_gen.sv
module lcd_sync_timing_gen
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pclk_falling_o,
    output logic [15:0]       pix_x_o,
    output logic [15:0]       pix_y_o
);

    lcdt_timing_t        live_tim;
    lcdt_timing_t        shadow_tim;
    logic [CFG_KEEP-1:0] cfg_bits;
    logic                req_start;
    logic                req_stop;
    logic                scanning;
    logic                draining;
    logic                load_start;
    logic                stop_done;
    logic                frame_last;
    logic                stat_bit;
    logic [2:0]          raw_sig;
    logic [2:0]          act_low;
    logic [2:0]          pins;
    logic [POS_W-1:0]    h_cnt;
    logic [POS_W-1:0]    v_cnt;

    // Views of shadow state for the bound checker.
    logic [POS_W-1:0]    h_tot_s;
    logic [POS_W-1:0]    v_tot_s;
    logic [SYNC_W-1:0]   hsw_s;

    lcdt_regfile #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .scanning    (scanning),
        .draining    (draining),
        .stop_done   (stop_done),
        .timing_o    (live_tim),
        .cfg_o       (cfg_bits),
        .req_start_o (req_start),
        .req_stop_o  (req_stop),
        .stat_o      (stat_bit)
    );

    lcdt_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_stop   (req_stop),
        .frame_last (frame_last),
        .scanning   (scanning),
        .draining   (draining),
        .load_start (load_start),
        .stop_done  (stop_done)
    );

    lcdt_scan u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_ce       (pix_ce),
        .scanning     (scanning),
        .load_start   (load_start),
        .live_i       (live_tim),
        .shadow_o     (shadow_tim),
        .h_o          (h_cnt),
        .v_o          (v_cnt),
        .frame_last_o (frame_last),
        .raw_o        (raw_sig)
    );

    assign act_low[0] = cfg_bits[CFG_HS_LOW - CFG_LSB];
    assign act_low[1] = cfg_bits[CFG_VS_LOW - CFG_LSB];
    assign act_low[2] = cfg_bits[CFG_DE_LOW - CFG_LSB];

    lcdt_pin_drive #(
        .N_SIG (3)
    ) u_pins (
        .raw_i     (raw_sig),
        .act_low_i (act_low),
        .pin_o     (pins)
    );

    assign hsync_o        = pins[0];
    assign vsync_o        = pins[1];
    assign de_o           = pins[2];
    assign pclk_falling_o = cfg_bits[CFG_PCLK_NEG - CFG_LSB];
    assign pix_x_o        = h_cnt;
    assign pix_y_o        = v_cnt;

    assign h_tot_s = shadow_tim.htot;
    assign v_tot_s = shadow_tim.vtot;
    assign hsw_s   = shadow_tim.hsw;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_ce,
    input logic              scanning,
    input logic [POS_W-1:0]  h_cnt,
    input logic [POS_W-1:0]  v_cnt,
    input logic [POS_W-1:0]  h_tot_s,
    input logic [POS_W-1:0]  v_tot_s,
    input logic [SYNC_W-1:0] hsw_s,
    input logic [2:0]        act_low,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              de_o,
    input logic              stat_bit,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata
);

    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == ADDR_W'(OFS_STATUS)) && !reg_wdata[0];

    p_hold_when_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> ($stable(h_cnt) && $stable(v_cnt)));

    p_pos_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> (h_cnt < h_tot_s) && (v_cnt < v_tot_s));

    p_line_sync_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && (POS_W'(hsw_s) > h_cnt)) |-> (hsync_o != act_low[0]));

    p_idle_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> (hsync_o == act_low[0]) && (vsync_o == act_low[1]) && (de_o == act_low[2]));

    p_stop_on_last_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scanning) |-> ($past(pix_ce) && ($past(h_cnt) + POS_W'(1) == $past(h_tot_s))
                             && ($past(v_cnt) + POS_W'(1) == $past(v_tot_s))));

    p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_bit && !clr_wr) |=> stat_bit);

endmodule

bind lcd_sync_timing_gen lcdt_checker #(
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ce    (pix_ce),
    .scanning  (scanning),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .h_tot_s   (h_tot_s),
    .v_tot_s   (v_tot_s),
    .hsw_s     (hsw_s),
    .act_low   (act_low),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .de_o      (de_o),
    .stat_bit  (stat_bit),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/lcd_sync_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_sync_timing_gen_tb_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_ce = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          hsync_o, vsync_o, de_o, pclk_falling_o;
    logic [15:0]   pix_x_o, pix_y_o;

    int n_checks = 0;
    int n_errors = 0;

    // Expected timing as programmed by the bench.
    int e_hsw, e_vsw, e_ht, e_vt, e_hb, e_he, e_vb, e_ve;
    bit p_h, p_v, p_d;

    always #2 clk = ~clk;

    lcd_sync_timing_gen #(.ADDR_W(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pix_ce         (pix_ce),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .hsync_o        (hsync_o),
        .vsync_o        (vsync_o),
        .de_o           (de_o),
        .pclk_falling_o (pclk_falling_o),
        .pix_x_o        (pix_x_o),
        .pix_y_o        (pix_y_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called and returning at a falling edge; spans one rising edge.
    task automatic wr(input int a, input logic [31:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #0.5;
        d = reg_rdata;
    endtask

    // Compare every output over n pixels, starting at frame position k0.
    task automatic scan_check(input int k0, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            int k  = k0 + i;
            int ex = k % e_ht;
            int ey = (k / e_ht) % e_vt;
            bit hs = (ex < e_hsw) ^ p_h;
            bit vs = (ey < e_vsw) ^ p_v;
            bit de = ((ex >= e_hb) && (ex < e_he) && (ey >= e_vb) && (ey < e_ve)) ^ p_d;
            if (pix_x_o != 16'(ex) || pix_y_o != 16'(ey) ||
                hsync_o != hs || vsync_o != vs || de_o != de) begin
                if (bad == 0)
                    $display("  mismatch at k=%0d: x=%0d/%0d y=%0d/%0d hs=%b/%b vs=%b/%b de=%b/%b",
                             k, pix_x_o, ex, pix_y_o, ey, hsync_o, hs, vsync_o, vs, de_o, de);
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, req, bad, 0);
    endtask

    // R13
    task automatic t_reset();
        logic [31:0] d;
        check(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R13 idle pins", {hsync_o, vsync_o, de_o}, 0);
        check(pix_x_o == 0 && pix_y_o == 0, "R13 positions", {pix_x_o, pix_y_o}, 0);
        rd('h0C, d); check(d == 0, "R13 totals reg", d, 0);
        rd('h34, d); check(d == 0, "R13 status reg", d, 0);
    endtask

    // R1
    task automatic t_regs();
        logic [31:0] d;
        wr('h08, 32'hFFFF_FFFF); rd('h08, d); check(d == 32'h3FF, "R1 line sync width field", d, 32'h3FF);
        wr('h00, 32'hFFFF_FFFF); rd('h00, d); check(d == 32'hF00, "R1 config kept bits", d, 32'hF00);
        wr('h00, 32'h0);
        e_hsw = 2; e_vsw = 1; e_ht = 11; e_vt = 6;
        e_hb = 5; e_he = 9; e_vb = 2; e_ve = 5;
        p_h = 0; p_v = 0; p_d = 0;
        wr('h08, 32'(e_hsw));
        wr('h04, 32'(e_vsw));
        wr('h0C, {16'(e_ht), 16'(e_vt)});
        wr('h10, {16'(e_hb), 16'(e_he)});
        wr('h14, {16'(e_vb), 16'(e_ve)});
        rd('h0C, d); check(d == 32'h000B_0006, "R1 totals packing", d, 32'h000B_0006);
        rd('h10, d); check(d == 32'h0005_0009, "R1 horizontal window packing", d, 32'h0005_0009);
        rd('h04, d); check(d == 32'h1, "R1 frame sync width", d, 1);
    endtask

    // R12, R10
    task automatic t_idle_stop();
        logic [31:0] d;
        wr('h30, 32'h10); rd('h34, d); check(d == 1, "R12 stop while idle sets status", d, 1);
        check(pix_x_o == 0 && hsync_o == 0, "R12 stays idle", pix_x_o, 0);
        wr('h34, 32'h1); rd('h34, d); check(d == 1, "R10 write of one keeps status", d, 1);
        wr('h34, 32'h0); rd('h34, d); check(d == 0, "R10 write of zero clears", d, 0);
    endtask

    // R3 R4 R5 R11
    task automatic t_frames();
        logic [31:0] d;
        wr('h30, 32'h08);
        rd('h30, d); check(d == 32'h08, "R11 control shows scanning", d, 32'h08);
        scan_check(0, 2 * e_ht * e_vt, "R3 R4 R5 two full frames");
    endtask

    // R2
    task automatic t_ce_hold();
        scan_check(0, 7, "R2 before hold");
        pix_ce = 1'b0;
        repeat (5) @(negedge clk);
        check(pix_x_o == 7 && pix_y_o == 0, "R2 positions hold without enable", pix_x_o, 7);
        pix_ce = 1'b1;
        scan_check(7, e_ht * e_vt - 7, "R2 resumes after hold");
    endtask

    // R6 R7
    task automatic t_polarity();
        wr('h00, 32'h0000_0F00);
        p_h = 1; p_v = 1; p_d = 1;
        check(pclk_falling_o == 1, "R7 falling edge select", pclk_falling_o, 1);
        scan_check(1, e_ht * e_vt - 1, "R6 all active low");
        wr('h00, 32'h0000_0000);
        p_h = 0; p_v = 0; p_d = 0;
        check(pclk_falling_o == 0, "R7 rising edge select", pclk_falling_o, 0);
        scan_check(1, e_ht * e_vt - 1, "R6 back to active high");
    endtask

    // R8
    task automatic t_shadow();
        wr('h08, 32'd4);
        wr('h10, {16'd6, 16'd8});
        scan_check(2, e_ht * e_vt - 2, "R8 frame in flight keeps old timing");
        e_hsw = 4; e_hb = 6; e_he = 8;
        scan_check(0, e_ht * e_vt, "R8 next frame uses new timing");
    endtask

    // R9 R10 R11
    task automatic t_stop();
        logic [31:0] d;
        int n = e_ht * e_vt;
        scan_check(0, 10, "R9 before stop");
        wr('h30, 32'h10);
        rd('h30, d); check(d == 32'h18, "R11 control shows stop pending", d, 32'h18);
        scan_check(11, n - 12, "R9 frame completes after stop request");
        rd('h34, d); check(d == 0, "R10 status clear before last pixel", d, 0);
        @(negedge clk);
        check(pix_x_o == 0 && pix_y_o == 0, "R9 positions zero after stop", {pix_x_o, pix_y_o}, 0);
        check(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R9 pins inactive after stop",
              {hsync_o, vsync_o, de_o}, 0);
        rd('h34, d); check(d == 1, "R10 status set after stop", d, 1);
        rd('h30, d); check(d == 0, "R11 control idle", d, 0);
        repeat (4) @(negedge clk);
        check(pix_x_o == 0, "R9 stays stopped", pix_x_o, 0);
    endtask

    // R11
    task automatic t_cancel();
        logic [31:0] d;
        wr('h34, 32'h0);
        wr('h30, 32'h08);
        wr('h30, 32'h18);
        rd('h30, d); check(d == 32'h18, "R11 both bits: stop wins", d, 32'h18);
        wr('h30, 32'h08);
        rd('h30, d); check(d == 32'h08, "R11 start cancels pending stop", d, 32'h08);
        scan_check(2, e_ht * e_vt + 3, "R11 scan continues past frame end");
        rd('h34, d); check(d == 0, "R11 no stop after cancel", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_idle_stop();
        t_frames();
        t_ce_hold();
        t_polarity();
        t_shadow();
        t_stop();
        t_cancel();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule